// File: doc/BRIEF.md
# Hitless Reference Switch Controller

This controller supervises a clock PLL while its reference input is swapped or jumps in phase. It watches three things: a stream of signed phase-error samples from the phase detector, the loop's lock flag and the reference-select input. Phase error is a signed count of fast-clock ticks. The controller arms only after the loop has locked. Once armed, it reacts to a reference reselection, or to a phase jump seen at the detector, in three steps. It forces the loop filter into its narrow-bandwidth setting. It then issues a one-cycle build-out command. That command tells the feedback divider how many oscillator periods to slip, so that the feedback edge lands on the oscillator edge nearest the new reference phase. Last, it holds the narrow setting until the measured error settles into a tighter window, and then arms again.

Phase-error samples arrive on a valid/ready stream. A sample moves when `smp_valid` and `smp_ready` are both high at a rising clock edge. While `smp_ready` is low, the source must hold `smp_valid` and `smp_err` steady. The controller pulls `smp_ready` low for one cycle only: the cycle in which it turns a captured sample into the build-out command. The build-out command, the bandwidth control and the armed flag are plain outputs with no handshake. The divider must take the command in the cycle its load pulse is high. Detection of phase jumps can be removed by a build parameter, for references that wander too much for transient detection to be useful.

Top module: `hitless_switch_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `hs_armed`, `narrow_bw` and `bo_load` are all 0.
- R2: The controller arms (`hs_armed`=1) in the cycle after a rising edge that samples `lock` high. While unarmed, neither a change of `ref_sel` nor a sample of any size drives `narrow_bw` high or produces `bo_load`.
- R3: When armed and locked, a change of `ref_sel` seen at an edge makes `narrow_bw`=1 and `hs_armed`=0 from the next cycle. The build-out offset is then computed from the next accepted sample.
- R4: When armed, locked and with transient detection built in (`JUMP_DETECT`=1), an accepted sample with |err| > `JUMP_TICKS` (default 40) starts the sequence and supplies the offset. A sample with |err| equal to `JUMP_TICKS` does not.
- R5: `bo_ofs` = err / `VCSO_TICKS` (default 16), rounded to the nearest integer with ties away from zero and saturated to the signed `OFS_W`-bit range (default -128..127). It is valid during a one-cycle `bo_load` pulse that comes in the cycle after the offset's sample was accepted. Each trigger yields exactly one pulse.
- R6: `smp_ready` is low only in the cycle that follows capture of the build-out sample, which is the cycle before `bo_load`. It is high in every other cycle.
- R7: After build-out, `narrow_bw` stays high until an accepted sample has |err| <= `SETTLE_TICKS` (default 20). From the next cycle `narrow_bw`=0 and `hs_armed`=1. A sample of 21 keeps the narrow setting.
- R8: Reference changes and large samples that arrive during build-out or narrow bandwidth are ignored. They produce no further `bo_load`, and after re-arming they do not start a new sequence.
- R9: If `lock` is sampled low in any state, the next cycle has `hs_armed`=0 and `narrow_bw`=0, and any build-out that was pending is dropped.
- R10: With `JUMP_DETECT`=0, no sample triggers the sequence, however large it is. Only changes of `ref_sel` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Active-high master reset |
| lock | input | 1 | Loop lock indication |
| ref_sel | input | 1 | Reference-select level |
| smp_valid | input | 1 | Phase-error sample valid |
| smp_ready | output | 1 | Controller accepts a sample |
| smp_err | input | ERR_W | Signed phase error in fast-clock ticks |
| narrow_bw | output | 1 | Forces the loop filter to narrow bandwidth |
| hs_armed | output | 1 | Switching protection is armed |
| bo_load | output | 1 | One-cycle build-out load pulse to the feedback divider |
| bo_ofs | output | OFS_W | Signed edge offset, in oscillator periods |

## Verification
The bench probes both jump and settle thresholds exactly at their limits (40 against 41, 20 against 21). A design that compared with the wrong inclusivity would trigger on a legal wobble, or would never release narrow bandwidth. A half-period tie is checked for rounding away from zero, and both ends of the error range are checked for saturation, so that a truncating or wrapping divider shows up as a wrong offset. Reference toggles and huge errors are sent while the loop is in narrow bandwidth, which catches a design that emits a second load or re-triggers later from a stale select. Lock is dropped with a build-out pending, which exposes a controller that still fires the load pulse. A second instance built without jump detection must stay wide on a large error and still follow a select change.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_ARMED    = 2'd1,
    ST_BUILDOUT = 2'd2,
    ST_NARROW   = 2'd3
  } hsw_state_e;
endpackage

// File: rtl/hsw_trigger_detect.sv
// Watches the select input and grades each accepted sample against the
// jump and settle windows.
module hsw_trigger_detect #(
  parameter int ERR_W        = 16,
  parameter int JUMP_TICKS   = 40,
  parameter int SETTLE_TICKS = 20,
  parameter bit JUMP_DETECT  = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ref_sel,
  input  logic signed [ERR_W-1:0] err,
  output logic                    sel_change,
  output logic                    big_jump,
  output logic                    in_window
);
  localparam int MAG_W = ERR_W + 1;
  localparam logic [MAG_W-1:0] JUMP_L   = MAG_W'(JUMP_TICKS);
  localparam logic [MAG_W-1:0] SETTLE_L = MAG_W'(SETTLE_TICKS);

  logic             sel_q;
  logic [MAG_W-1:0] ext;
  logic [MAG_W-1:0] mag;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= 1'b0;
    else     sel_q <= ref_sel;
  end

  assign sel_change = ref_sel ^ sel_q;

  always_comb begin
    ext = {err[ERR_W-1], err};
    mag = err[ERR_W-1] ? (~ext + MAG_W'(1)) : ext;
  end

  assign in_window = (mag <= SETTLE_L);

  generate
    if (JUMP_DETECT) begin : g_jump
      assign big_jump = (mag > JUMP_L);
    end else begin : g_nojump
      assign big_jump = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/hsw_edge_picker.sv
// Turns a phase error in ticks into a whole number of oscillator periods,
// rounding half away from zero and clamping to the offset width.
module hsw_edge_picker #(
  parameter int ERR_W      = 16,
  parameter int VCSO_TICKS = 16,
  parameter int OFS_W      = 8
) (
  input  logic signed [ERR_W-1:0] err,
  output logic signed [OFS_W-1:0] ofs
);
  localparam int SUM_W = ERR_W + 2;
  localparam logic [SUM_W-1:0] HALF_L = SUM_W'(VCSO_TICKS / 2);
  localparam logic [SUM_W-1:0] DIV_L  = SUM_W'(VCSO_TICKS);
  localparam logic [SUM_W-1:0] MAXP_L = SUM_W'((2 ** (OFS_W - 1)) - 1);
  localparam logic [SUM_W-1:0] MAXN_L = SUM_W'(2 ** (OFS_W - 1));

  logic             neg;
  logic [SUM_W-1:0] ext;
  logic [SUM_W-1:0] mag;
  logic [SUM_W-1:0] quo;
  logic [OFS_W-1:0] q_lo;

  always_comb begin
    neg  = err[ERR_W-1];
    ext  = {{2{err[ERR_W-1]}}, err};
    mag  = neg ? (~ext + SUM_W'(1)) : ext;
    quo  = (mag + HALF_L) / DIV_L;
    q_lo = quo[OFS_W-1:0];
    if (neg) begin
      if (quo >= MAXN_L) ofs = {1'b1, {(OFS_W-1){1'b0}}};
      else               ofs = ~q_lo + OFS_W'(1);
    end else begin
      if (quo >= MAXP_L) ofs = {1'b0, {(OFS_W-1){1'b1}}};
      else               ofs = q_lo;
    end
  end
endmodule

// File: rtl/hsw_fsm.sv
// Sequencer: arm on lock, trigger, capture, issue build-out, settle, re-arm.
module hsw_fsm
  import hsw_pkg::*;
#(
  parameter int ERR_W = 16,
  parameter int OFS_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    lock,
  input  logic                    sel_change,
  input  logic                    fire,
  input  logic                    big_jump,
  input  logic                    in_window,
  input  logic signed [ERR_W-1:0] smp_err,
  input  logic signed [OFS_W-1:0] picked_ofs,
  output logic signed [ERR_W-1:0] held_err,
  output logic                    smp_ready,
  output logic                    narrow_bw,
  output logic                    hs_armed,
  output logic                    bo_load,
  output logic signed [OFS_W-1:0] bo_ofs
);
  hsw_state_e state;
  logic       have;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      have     <= 1'b0;
      held_err <= '0;
      bo_load  <= 1'b0;
      bo_ofs   <= '0;
    end else begin
      bo_load <= 1'b0;
      if (!lock) begin
        state <= ST_IDLE;
        have  <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: state <= ST_ARMED;
          ST_ARMED: begin
            if (sel_change) begin
              state <= ST_BUILDOUT;
              have  <= 1'b0;
            end else if (fire && big_jump) begin
              state    <= ST_BUILDOUT;
              have     <= 1'b1;
              held_err <= smp_err;
            end
          end
          ST_BUILDOUT: begin
            if (have) begin
              bo_load <= 1'b1;
              bo_ofs  <= picked_ofs;
              have    <= 1'b0;
              state   <= ST_NARROW;
            end else if (fire) begin
              held_err <= smp_err;
              have     <= 1'b1;
            end
          end
          ST_NARROW: begin
            if (fire && in_window) state <= ST_ARMED;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign smp_ready = !((state == ST_BUILDOUT) && have);
  assign narrow_bw = (state == ST_BUILDOUT) || (state == ST_NARROW);
  assign hs_armed  = (state == ST_ARMED);
endmodule

// File: rtl/hitless_switch_ctrl.sv
module hitless_switch_ctrl #(
  parameter int ERR_W        = 16,
  parameter int OFS_W        = 8,
  parameter int VCSO_TICKS   = 16,
  parameter int JUMP_TICKS   = 40,
  parameter int SETTLE_TICKS = 20,
  parameter bit JUMP_DETECT  = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    lock,
  input  logic                    ref_sel,
  input  logic                    smp_valid,
  output logic                    smp_ready,
  input  logic signed [ERR_W-1:0] smp_err,
  output logic                    narrow_bw,
  output logic                    hs_armed,
  output logic                    bo_load,
  output logic signed [OFS_W-1:0] bo_ofs
);
  logic                    sel_change;
  logic                    big_jump;
  logic                    in_window;
  logic                    fire;
  logic signed [ERR_W-1:0] held_err;
  logic signed [OFS_W-1:0] picked_ofs;

  assign fire = smp_valid && smp_ready;

  hsw_trigger_detect #(
    .ERR_W(ERR_W), .JUMP_TICKS(JUMP_TICKS),
    .SETTLE_TICKS(SETTLE_TICKS), .JUMP_DETECT(JUMP_DETECT)
  ) u_detect (
    .clk(clk), .rst(rst), .ref_sel(ref_sel), .err(smp_err),
    .sel_change(sel_change), .big_jump(big_jump), .in_window(in_window)
  );

  hsw_edge_picker #(
    .ERR_W(ERR_W), .VCSO_TICKS(VCSO_TICKS), .OFS_W(OFS_W)
  ) u_pick (
    .err(held_err), .ofs(picked_ofs)
  );

  hsw_fsm #(.ERR_W(ERR_W), .OFS_W(OFS_W)) u_fsm (
    .clk(clk), .rst(rst), .lock(lock), .sel_change(sel_change),
    .fire(fire), .big_jump(big_jump), .in_window(in_window),
    .smp_err(smp_err), .picked_ofs(picked_ofs), .held_err(held_err),
    .smp_ready(smp_ready), .narrow_bw(narrow_bw), .hs_armed(hs_armed),
    .bo_load(bo_load), .bo_ofs(bo_ofs)
  );
endmodule

// File: rtl/hsw_checker.sv
module hsw_checker #(
  parameter int ERR_W       = 16,
  parameter int JUMP_TICKS  = 40,
  parameter bit JUMP_DETECT = 1'b1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    lock,
  input logic                    ref_sel,
  input logic                    smp_valid,
  input logic                    smp_ready,
  input logic signed [ERR_W-1:0] smp_err,
  input logic                    narrow_bw,
  input logic                    hs_armed,
  input logic                    bo_load
);
  logic signed [ERR_W:0] wide;
  logic                  jump_seen;
  assign wide      = ERR_W'(1) == 0 ? '0 : {smp_err[ERR_W-1], smp_err};
  assign jump_seen = (wide > (ERR_W+1)'(JUMP_TICKS)) || (wide < -(ERR_W+1)'(JUMP_TICKS));

  p_rst_quiet_r1: assert property (@(posedge clk) rst |=> !bo_load && !narrow_bw);
  p_idle_no_narrow_r2: assert property (@(posedge clk) disable iff (rst)
    (!hs_armed && !narrow_bw) |=> !narrow_bw);
  p_sel_trigger_r3: assert property (@(posedge clk) disable iff (rst)
    (hs_armed && lock && !$stable(ref_sel)) |=> (narrow_bw && !hs_armed));
  p_jump_trigger_r4: assert property (@(posedge clk) disable iff (rst)
    (JUMP_DETECT && hs_armed && lock && smp_valid && smp_ready && jump_seen) |=> narrow_bw);
  p_load_single_r5: assert property (@(posedge clk) disable iff (rst)
    bo_load |=> !bo_load);
  p_stall_then_load_r6: assert property (@(posedge clk) disable iff (rst)
    (!smp_ready && lock) |=> bo_load);
  p_load_in_narrow_r8: assert property (@(posedge clk) disable iff (rst)
    bo_load |-> narrow_bw);
  p_lock_loss_r9: assert property (@(posedge clk) disable iff (rst)
    !lock |=> (!narrow_bw && !hs_armed && !bo_load));
  p_no_jump_trig_r10: assert property (@(posedge clk) disable iff (rst)
    (!JUMP_DETECT && hs_armed && $stable(ref_sel)) |=> !narrow_bw);
  p_modes_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hs_armed, narrow_bw}));
endmodule

bind hitless_switch_ctrl hsw_checker #(
  .ERR_W(ERR_W), .JUMP_TICKS(JUMP_TICKS), .JUMP_DETECT(JUMP_DETECT)
) u_hsw_checker (
  .clk(clk), .rst(rst), .lock(lock), .ref_sel(ref_sel),
  .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_err(smp_err),
  .narrow_bw(narrow_bw), .hs_armed(hs_armed), .bo_load(bo_load)
);

// File: tb/hitless_switch_ctrl_bench.sv
module hitless_switch_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lock = 1'b0, ref_sel = 1'b0, smp_valid = 1'b0;
  logic signed [15:0] smp_err = '0;
  logic smp_ready, narrow_bw, hs_armed, bo_load;
  logic signed [7:0] bo_ofs;

  logic lock2 = 1'b0, sel2 = 1'b0, valid2 = 1'b0;
  logic signed [15:0] err2 = '0;
  logic ready2, narrow2, armed2, load2;
  logic signed [7:0] ofs2;

  int checks = 0, errors = 0, loads_seen = 0, loads2 = 0, pushed = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hitless_switch_ctrl u_hitless_switch_ctrl (
    .clk(clk), .rst(rst), .lock(lock), .ref_sel(ref_sel),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_err(smp_err),
    .narrow_bw(narrow_bw), .hs_armed(hs_armed), .bo_load(bo_load), .bo_ofs(bo_ofs)
  );

  hitless_switch_ctrl #(.JUMP_DETECT(1'b0)) u_hitless_switch_ctrl_nojump (
    .clk(clk), .rst(rst), .lock(lock2), .ref_sel(sel2),
    .smp_valid(valid2), .smp_ready(ready2), .smp_err(err2),
    .narrow_bw(narrow2), .hs_armed(armed2), .bo_load(load2), .bo_ofs(ofs2)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: offers one sample, pushes the expected offset when it triggers
  task automatic send(input int e, input bit expect_load, input int exp_ofs);
    if (expect_load) begin exp_q.push_back(exp_ofs); pushed++; end
    smp_valid = 1'b1;
    smp_err   = 16'(e);
    while (!smp_ready) @(negedge clk);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic send2(input int e);
    valid2 = 1'b1;
    err2   = 16'(e);
    while (!ready2) @(negedge clk);
    @(negedge clk);
    valid2 = 1'b0;
  endtask

  // monitor: scoreboard for build-out commands
  always @(negedge clk) begin
    if (!rst && bo_load) begin
      loads_seen++;
      if (exp_q.size() == 0) check(1'b0, "R5 unexpected load", int'(bo_ofs), 0);
      else begin
        int e;
        e = exp_q.pop_front();
        check(int'(bo_ofs) == e, "R5 offset", int'(bo_ofs), e);
      end
    end
    if (!rst && load2) begin
      loads2++;
      check(int'(ofs2) == 1, "R10 offset", int'(ofs2), 1);
    end
  end

  initial begin
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    check(!hs_armed && !narrow_bw && !bo_load, "R1 in reset", {hs_armed, narrow_bw, bo_load}, 0);
    rst = 1'b0;
    step(1);
    check(!hs_armed && !narrow_bw && !bo_load, "R1 after reset", {hs_armed, narrow_bw, bo_load}, 0);

    // R2: unarmed ignores triggers
    ref_sel = 1'b1;
    step(1);
    send(200, 1'b0, 0);
    check(!narrow_bw && !hs_armed, "R2 unarmed", {hs_armed, narrow_bw}, 0);
    lock = 1'b1; lock2 = 1'b1;
    step(1);
    check(hs_armed == 1'b1, "R2 arm on lock", hs_armed, 1);

    // R3: select change trigger, offset from next sample
    ref_sel = 1'b0;
    step(1);
    check(narrow_bw && !hs_armed, "R3 select trigger", {hs_armed, narrow_bw}, 1);
    send(40, 1'b1, 3);
    check(smp_ready == 1'b0, "R6 ready low before load", smp_ready, 0);
    step(1);
    check(smp_ready == 1'b1, "R6 ready back", smp_ready, 1);

    // R8: ignored while narrow; R7: settle window edge
    ref_sel = 1'b1;
    send(300, 1'b0, 0);
    check(narrow_bw == 1'b1, "R8 narrow held", narrow_bw, 1);
    send(21, 1'b0, 0);
    check(narrow_bw == 1'b1, "R7 21 outside window", narrow_bw, 1);
    send(20, 1'b0, 0);
    check(hs_armed && !narrow_bw, "R7 re-armed at 20", {hs_armed, narrow_bw}, 2);
    step(2);
    check(!narrow_bw && loads_seen == 1, "R8 no retrigger", loads_seen, 1);

    // R4: jump threshold
    send(40, 1'b0, 0);
    check(hs_armed && !narrow_bw, "R4 40 no trigger", narrow_bw, 0);
    send(-100, 1'b1, -6);
    check(narrow_bw == 1'b1, "R4 jump trigger", narrow_bw, 1);
    step(1);
    send(0, 1'b0, 0);
    check(hs_armed == 1'b1, "R7 settle after jump", hs_armed, 1);

    // R5: tie and saturation
    send(56, 1'b1, 4);   step(1); send(-5, 1'b0, 0);
    send(-41, 1'b1, -3); step(1); send(0, 1'b0, 0);
    send(32767, 1'b1, 127);   step(1); send(0, 1'b0, 0);
    send(-32768, 1'b1, -128); step(1); send(0, 1'b0, 0);
    check(hs_armed == 1'b1, "R5 armed after sweep", hs_armed, 1);

    // R9: loss of lock
    ref_sel = 1'b0;
    step(1);
    lock = 1'b0;
    step(1);
    check(!narrow_bw && !hs_armed, "R9 lock loss narrow", {hs_armed, narrow_bw}, 0);
    lock = 1'b1;
    step(1);
    send(500, 1'b0, 0);
    lock = 1'b0;
    step(2);
    check(!narrow_bw && !bo_load, "R9 pending dropped", narrow_bw, 0);
    lock = 1'b1;
    step(1);
    check(hs_armed == 1'b1, "R9 re-arm", hs_armed, 1);

    // R10: jump detection removed
    send2(500);
    check(!narrow2 && armed2, "R10 no jump trigger", narrow2, 0);
    sel2 = 1'b1;
    step(1);
    check(narrow2 == 1'b1, "R10 select still triggers", narrow2, 1);
    send2(16);
    step(1);
    send2(0);
    check(armed2 && loads2 == 1, "R10 one load", loads2, 1);

    step(2);
    check(exp_q.size() == 0 && loads_seen == pushed, "R5 load count", loads_seen, pushed);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule